// File: doc/BRIEF.md
# Command-Mode LCD Parallel Write Interface

This block writes to a command-mode LCD panel over an 8-bit parallel bus. Each transfer is either one pixel from a valid/ready stream, which stands in for a DMA feed, or one command or parameter byte from a host register-write port. A pixel is split into bus beats, most significant byte first: two beats for 16-bit 5-6-5 colour and three beats for 24-bit 8-8-8 colour.

The bus can use either of two signalling styles. In the first, separate active-low write and read strobes are used. In the second, an active-high enable pulse is used together with a read/write direction line. The active and inactive times of the strobe are each programmable from 1 to 16 clock cycles. The block latches its configuration when it accepts a transfer, and it only writes to the panel.

Top module: `slcd_bus_if`

## Requirements
- R1: After reset, lcd_cs_no, lcd_wstb_rw_o and lcd_rstb_en_o are 1, and both pix_ready_o and reg_ready_o are 1.
- R2: With cfg_style_i=0 (strobe pair), lcd_wstb_rw_o is the active-low write strobe, and lcd_rstb_en_o stays at 1 for the whole transfer.
- R3: With cfg_style_i=1 (enable style), lcd_rstb_en_o is an active-high enable pulse, and lcd_wstb_rw_o (read/write, 0 means write) stays at 0 for the whole transfer.
- R4: With cfg_fmt888_i=0, a pixel takes exactly two beats: pix_data_i[15:8] first, then pix_data_i[7:0]. Bits [23:16] are not sent.
- R5: With cfg_fmt888_i=1, a pixel takes exactly three beats, in this order: [23:16] (red), [15:8] (green), [7:0] (blue).
- R6: A register write takes exactly one beat. It carries reg_data_i, and lcd_rs_o equals reg_is_data_i (0 for a command, 1 for data).
- R7: lcd_rs_o is 1 for every pixel beat. lcd_rs_o and lcd_d_o do not change while a strobe is active.
- R8: Each strobe stays active for exactly cfg_low_i+1 cycles, so the 4-bit field gives 1 to 16 cycles.
- R9: Between beats, and after the last beat, the strobe stays inactive for exactly cfg_high_i+1 cycles.
- R10: lcd_cs_no falls exactly one cycle before the first strobe. It stays low through all beats and rises right after the last inactive phase.
- R11: pix_ready_o is 0 throughout a transfer, so no new pixel is accepted until the final beat of the current one has finished.
- R12: If reg_wr_i and pix_valid_i are both 1 while the block is idle, the register write is taken and pix_ready_o is 0.
- R13: The style, format, low time and high time are captured when a transfer is accepted. Changing them during the transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_style_i | input | 1 | Bus style: 0 = strobe pair, 1 = enable plus R/W |
| cfg_fmt888_i | input | 1 | Pixel format: 0 = 5-6-5, 1 = 8-8-8 |
| cfg_low_i | input | 4 | Strobe active time minus one |
| cfg_high_i | input | 4 | Strobe inactive time minus one |
| pix_valid_i | input | 1 | Pixel stream valid |
| pix_data_i | input | 24 | Pixel word |
| pix_ready_o | output | 1 | Pixel stream ready |
| reg_wr_i | input | 1 | Register write request |
| reg_is_data_i | input | 1 | Register write kind: 0 = command, 1 = data |
| reg_data_i | input | 8 | Register write byte |
| reg_ready_o | output | 1 | Register write accepted when 1 |
| lcd_cs_no | output | 1 | Panel select, active low |
| lcd_rs_o | output | 1 | Register/data select |
| lcd_wstb_rw_o | output | 1 | Write strobe (style 0) or R/W line (style 1) |
| lcd_rstb_en_o | output | 1 | Read strobe (style 0) or enable (style 1) |
| lcd_d_o | output | 8 | Panel data bus |

## Verification
The bench uses the default parameters: a 24-bit pixel, an 8-bit bus and 4-bit timing fields. With these values, both pixel formats exist as two- and three-beat sequences. The timing extremes (1 and 16 cycles) are short enough to measure directly on every beat. The vectors cover both bus styles with each format, and both command and data register writes. The directed tests cover a simultaneous request on both ports and configuration changes during a transfer.

// File: rtl/slcd_pkg.sv
package slcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ACT   = 2'd2,
    ST_HOLD  = 2'd3
  } slcd_state_e;

  // beats per transfer: register writes are one byte
  function automatic int unsigned beats_for(input logic is_reg, input logic fmt888,
                                            input int unsigned pix_w, input int unsigned dw);
    if (is_reg) return 1;
    return fmt888 ? (pix_w / dw) : (16 / dw);
  endfunction
endpackage

// File: rtl/slcd_phase_timer.sv
module slcd_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || !en_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == lim_i);

  // R8
  phase_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= lim_i));
endmodule

// File: rtl/slcd_beat_packer.sv
module slcd_beat_packer #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned DW    = 8,
  parameter int unsigned IDX_W = 2
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic             fmt888_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [DW-1:0]    byte_o
);
  localparam int unsigned NB_MAX = PIX_W / DW;
  localparam int unsigned NB_565 = 16 / DW;
  localparam int unsigned SKIP   = NB_MAX - NB_565;

  logic [DW-1:0]  lanes [NB_MAX];
  logic [IDX_W:0] sel;

  // lane 0 is the most significant byte
  for (genvar g = 0; g < NB_MAX; g++) begin : g_lane
    assign lanes[g] = pix_i[PIX_W-1-g*DW -: DW];
  end

  assign sel = {1'b0, idx_i} + (fmt888_i ? '0 : (IDX_W+1)'(SKIP));

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NB_MAX; i++)
      if (sel == (IDX_W+1)'(i)) byte_o = lanes[i];
  end
endmodule

// File: rtl/slcd_xfer_fsm.sv
module slcd_xfer_fsm
  import slcd_pkg::*;
#(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_style_i,
  input  logic             cfg_fmt888_i,
  input  logic [CNT_W-1:0] cfg_low_i,
  input  logic [CNT_W-1:0] cfg_high_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             reg_wr_i,
  input  logic             reg_is_data_i,
  input  logic [DW-1:0]    reg_data_i,
  input  logic             tmr_done_i,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic [CNT_W-1:0] tmr_lim_o,
  output logic             idle_o,
  output logic             cs_act_o,
  output logic             strobe_act_o,
  output logic             rs_o,
  output logic             style_o,
  output logic             fmt888_o,
  output logic [PIX_W-1:0] pix_o,
  output logic [IDX_W-1:0] idx_o
);
  slcd_state_e      st_q, st_d;
  logic             take_reg, take_pix;
  logic [IDX_W-1:0] idx_q, nb_q;
  logic             last_q, rs_q, style_q, fmt_q;
  logic [CNT_W-1:0] low_q, high_q;
  logic [PIX_W-1:0] pix_q;

  assign idle_o   = (st_q == ST_IDLE);
  assign take_reg = idle_o && reg_wr_i;
  assign take_pix = idle_o && pix_valid_i && !reg_wr_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (take_reg || take_pix) st_d = ST_SETUP;
      ST_SETUP: st_d = ST_ACT;
      ST_ACT:   if (tmr_done_i) st_d = ST_HOLD;
      ST_HOLD:  if (tmr_done_i) st_d = last_q ? ST_IDLE : ST_ACT;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      nb_q    <= '0;
      last_q  <= 1'b0;
      rs_q    <= 1'b0;
      style_q <= 1'b0;
      fmt_q   <= 1'b0;
      low_q   <= '0;
      high_q  <= '0;
      pix_q   <= '0;
    end else begin
      st_q <= st_d;
      if (take_reg || take_pix) begin
        idx_q   <= '0;
        last_q  <= 1'b0;
        style_q <= cfg_style_i;
        low_q   <= cfg_low_i;
        high_q  <= cfg_high_i;
      end
      if (take_reg) begin
        // reg byte rides in the top lane of a three-beat frame cut to one beat
        pix_q <= {reg_data_i, {(PIX_W-DW){1'b0}}};
        fmt_q <= 1'b1;
        nb_q  <= IDX_W'(beats_for(1'b1, 1'b1, PIX_W, DW));
        rs_q  <= reg_is_data_i;
      end else if (take_pix) begin
        pix_q <= pix_data_i;
        fmt_q <= cfg_fmt888_i;
        nb_q  <= IDX_W'(beats_for(1'b0, cfg_fmt888_i, PIX_W, DW));
        rs_q  <= 1'b1;
      end
      // advance data at strobe release so it is settled before the next strobe
      if (st_q == ST_ACT && tmr_done_i) begin
        last_q <= (idx_q == nb_q - 1'b1);
        if (idx_q != nb_q - 1'b1) idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign tmr_clr_o    = (st_d != st_q);
  assign tmr_en_o     = !idle_o;
  assign tmr_lim_o    = (st_q == ST_ACT) ? low_q : (st_q == ST_HOLD) ? high_q : '0;
  assign cs_act_o     = !idle_o;
  assign strobe_act_o = (st_q == ST_ACT);
  assign rs_o         = rs_q;
  assign style_o      = style_q;
  assign fmt888_o     = fmt_q;
  assign pix_o        = pix_q;
  assign idx_o        = idx_q;

  // R7
  rs_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_act_o && $past(cs_act_o) |-> $stable(rs_o));
  // R7
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_act_o && $past(strobe_act_o) |-> $stable(idx_q) && $stable(pix_q));
  // R10
  cs_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_act_o) |-> $past(cs_act_o));
  // R10
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_act_o) |-> $past(last_q) && $past(st_q == ST_HOLD));
  // R13
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_act_o && $past(cs_act_o) |-> $stable(low_q) && $stable(high_q) && $stable(style_q));
endmodule

// File: rtl/slcd_bus_if.sv
module slcd_bus_if #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_style_i,
  input  logic             cfg_fmt888_i,
  input  logic [CNT_W-1:0] cfg_low_i,
  input  logic [CNT_W-1:0] cfg_high_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             pix_ready_o,
  input  logic             reg_wr_i,
  input  logic             reg_is_data_i,
  input  logic [DW-1:0]    reg_data_i,
  output logic             reg_ready_o,
  output logic             lcd_cs_no,
  output logic             lcd_rs_o,
  output logic             lcd_wstb_rw_o,
  output logic             lcd_rstb_en_o,
  output logic [DW-1:0]    lcd_d_o
);
  localparam int unsigned IDX_W = $clog2(PIX_W / DW + 1);

  logic             tmr_done, tmr_clr, tmr_en;
  logic [CNT_W-1:0] tmr_lim;
  logic             idle, cs_act, strobe_act, rs, style, fmt888;
  logic [PIX_W-1:0] pix;
  logic [IDX_W-1:0] idx;

  slcd_xfer_fsm #(.PIX_W(PIX_W), .DW(DW), .CNT_W(CNT_W), .IDX_W(IDX_W)) fsm_i (
    .clk_i, .rst_ni, .cfg_style_i, .cfg_fmt888_i, .cfg_low_i, .cfg_high_i,
    .pix_valid_i, .pix_data_i, .reg_wr_i, .reg_is_data_i, .reg_data_i,
    .tmr_done_i(tmr_done), .tmr_clr_o(tmr_clr), .tmr_en_o(tmr_en), .tmr_lim_o(tmr_lim),
    .idle_o(idle), .cs_act_o(cs_act), .strobe_act_o(strobe_act), .rs_o(rs),
    .style_o(style), .fmt888_o(fmt888), .pix_o(pix), .idx_o(idx)
  );

  slcd_phase_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .en_i(tmr_en), .lim_i(tmr_lim), .done_o(tmr_done)
  );

  slcd_beat_packer #(.PIX_W(PIX_W), .DW(DW), .IDX_W(IDX_W)) pack_i (
    .pix_i(pix), .fmt888_i(fmt888), .idx_i(idx), .byte_o(lcd_d_o)
  );

  assign pix_ready_o   = idle && !reg_wr_i;
  assign reg_ready_o   = idle;
  assign lcd_cs_no     = !cs_act;
  assign lcd_rs_o      = rs;
  // style 0: active-low write strobe; style 1: R/W held at write
  assign lcd_wstb_rw_o = style ? 1'b0 : !strobe_act;
  // style 0: read strobe parked high; style 1: active-high enable
  assign lcd_rstb_en_o = style ? strobe_act : 1'b1;

  // R11
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |-> lcd_cs_no);
  // R2
  rstb_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !style && !lcd_cs_no |-> lcd_rstb_en_o);
  // R3
  rw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    style && !lcd_cs_no |-> !lcd_wstb_rw_o);
  // R12
  reg_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |-> !pix_ready_o);
endmodule

// File: tb/slcd_bus_if_tb_top.sv
`timescale 1ns/1ps
module slcd_bus_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_style = 1'b0, cfg_fmt = 1'b0;
  logic [3:0]  cfg_low = '0, cfg_high = '0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_ready, reg_ready;
  logic        reg_wr = 1'b0, reg_is_data = 1'b0;
  logic [7:0]  reg_data = '0;
  logic        cs_n, rs, wstb, rstb;
  logic [7:0]  d;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  slcd_bus_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_style_i(cfg_style), .cfg_fmt888_i(cfg_fmt),
    .cfg_low_i(cfg_low), .cfg_high_i(cfg_high), .pix_valid_i(pix_valid),
    .pix_data_i(pix_data), .pix_ready_o(pix_ready), .reg_wr_i(reg_wr),
    .reg_is_data_i(reg_is_data), .reg_data_i(reg_data), .reg_ready_o(reg_ready),
    .lcd_cs_no(cs_n), .lcd_rs_o(rs), .lcd_wstb_rw_o(wstb), .lcd_rstb_en_o(rstb), .lcd_d_o(d)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {is_reg, style, fmt888, low, high, rs, data}
  localparam int VW = 36;
  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd0,  1'b1, 24'h00A5C3},
    {1'b0, 1'b0, 1'b1, 4'd2,  4'd1,  1'b1, 24'h123456},
    {1'b0, 1'b1, 1'b0, 4'd1,  4'd3,  1'b1, 24'hFF0FF0},
    {1'b0, 1'b1, 1'b1, 4'd15, 4'd15, 1'b1, 24'h80017E},
    {1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0, 24'h00002C},
    {1'b1, 1'b1, 1'b1, 4'd3,  4'd2,  1'b1, 24'h00005A},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd15, 1'b1, 24'hFFFFFF},
    {1'b1, 1'b0, 1'b0, 4'd15, 4'd0,  1'b0, 24'h000000}
  };

  // called at a negedge while idle
  task automatic run_xfer(input logic is_reg, input logic sty, input logic fmt,
                          input logic [3:0] low, input logic [3:0] high, input logic rsv,
                          input logic [23:0] data, input logic both, input logic scramble);
    int nb_exp, nb, run, guard;
    logic act, prev_act, side_ok, rs_ok, stab_ok;
    logic [7:0] exp_b, cur_b;
    cfg_style = sty; cfg_fmt = fmt; cfg_low = low; cfg_high = high;
    if (is_reg) begin
      reg_wr = 1'b1; reg_data = data[7:0]; reg_is_data = rsv;
      pix_valid = both; pix_data = 24'h777777;
    end else begin
      pix_valid = 1'b1; pix_data = data;
    end
    #1;
    if (both) chk(pix_ready == 1'b0, "R12 pix_ready with reg_wr", 32'(pix_ready), 0);
    @(negedge clk);
    reg_wr = 1'b0; pix_valid = 1'b0;
    if (scramble) begin
      cfg_style = ~sty; cfg_fmt = ~fmt; cfg_low = ~low; cfg_high = ~high;
    end
    chk(pix_ready == 1'b0 && cs_n == 1'b0, "R11 ready low in transfer", 32'({pix_ready, cs_n}), 0);
    nb_exp = is_reg ? 1 : (fmt ? 3 : 2);
    nb = 0; run = 0; guard = 0; prev_act = 1'b0;
    side_ok = 1'b1; rs_ok = 1'b1; stab_ok = 1'b1; cur_b = '0;
    while (cs_n == 1'b0 && guard < 2000) begin
      act = sty ? rstb : !wstb;
      if (sty) begin if (wstb !== 1'b0) side_ok = 1'b0; end
      else     begin if (rstb !== 1'b1) side_ok = 1'b0; end
      if (act) begin
        if (!prev_act) begin
          if (nb == 0) chk(run == 1, "R10 cs lead one cycle", 32'(run), 1);
          else         chk(run == int'(high) + 1, "R9 inactive time", 32'(run), 32'(high) + 1);
          run = 0; cur_b = d;
        end else if (d !== cur_b) stab_ok = 1'b0;
        if (rs !== (is_reg ? rsv : 1'b1)) rs_ok = 1'b0;
        run++;
      end else begin
        if (prev_act) begin
          chk(run == int'(low) + 1, "R8 active time", 32'(run), 32'(low) + 1);
          exp_b = is_reg ? data[7:0] : fmt ? data[23 - 8*nb -: 8] : data[15 - 8*nb -: 8];
          chk(cur_b == exp_b, is_reg ? "R6 reg byte" : (fmt ? "R5 888 byte" : "R4 565 byte"),
              32'(cur_b), 32'(exp_b));
          nb++; run = 0;
        end
        run++;
      end
      prev_act = act;
      guard++;
      @(negedge clk);
    end
    chk(nb == nb_exp, is_reg ? "R6 beat count" : (fmt ? "R5 beat count" : "R4 beat count"),
        32'(nb), 32'(nb_exp));
    chk(!prev_act && run == int'(high) + 1, "R10 cs release after last inactive phase",
        32'(run), 32'(high) + 1);
    chk(side_ok, sty ? "R3 R/W held low" : "R2 read strobe held high", 32'(side_ok), 1);
    chk(rs_ok, is_reg ? "R6 rs level" : "R7 rs high for pixels", 32'(rs_ok), 1);
    chk(stab_ok, "R7 data stable under strobe", 32'(stab_ok), 1);
    if (scramble) chk(nb == nb_exp, "R13 config latched", 32'(nb), 32'(nb_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({cs_n, wstb, rstb, pix_ready, reg_ready} == 5'b11111, "R1 reset state",
        32'({cs_n, wstb, rstb, pix_ready, reg_ready}), 32'h1f);

    for (int i = 0; i < NV; i++) begin
      run_xfer(VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32:29], VEC[i][28:25],
               VEC[i][24], VEC[i][23:0], 1'b0, 1'b0);
      @(negedge clk);
    end

    // R12: both ports request together
    run_xfer(1'b1, 1'b0, 1'b0, 4'd1, 4'd1, 1'b0, 24'h0000B7, 1'b1, 1'b0);
    @(negedge clk);
    // R13: config flipped right after accept, 565 enable-style pixel
    run_xfer(1'b0, 1'b1, 1'b0, 4'd2, 4'd4, 1'b1, 24'hC0FFEE, 1'b0, 1'b1);
    @(negedge clk);
    // R13: 888 strobe-pair pixel with config flipped
    run_xfer(1'b0, 1'b0, 1'b1, 4'd5, 4'd0, 1'b1, 24'h3C5A96, 1'b0, 1'b1);
    @(negedge clk);
    chk(cs_n == 1'b1 && pix_ready == 1'b1, "R11 ready back after transfer",
        32'({cs_n, pix_ready}), 3);
    summary();
  end
endmodule